// File: doc/BRIEF.md
# I2C Register Port

This block is an I2C target that lets an external host read and write a bank of sixteen 8-bit registers held inside it. The SCL and SDA lines are brought in through a synchronizer. From those samples the block finds bus START and STOP conditions and the clock edges. The block drives SDA only through an active-low enable (`sda_oe` high pulls the line low). Any level it does not drive counts as released.

A host writes by sending the 7-bit device address with the write bit, then a byte that sets an internal register pointer, then any number of data bytes. Each data byte goes into the bank and also appears on a one-cycle write strobe. To read, the host sets the pointer in the same way, issues a repeated START, and sends the address with the read bit. The block then returns registers from the pointer onward for as long as the host acknowledges.

A START that is not closed by a STOP within 0.95 s trips a timer. The limit is derived from the system clock frequency parameter. On that event the block releases SDA and ignores the bus until the next START.

Top module: `i2c_regport`

## Requirements
- R1: After reset `sda_oe` and `wr_en` are 0, and SDA stays released whenever no acknowledge or read bit is owed.
- R2: A START (SDA falling while SCL is high) begins a new address phase from any state, including part way through a byte. A STOP (SDA rising while SCL is high) ends the transaction and releases SDA.
- R3: Only the address 7'b0110010 is acknowledged; the eighth bit of the address byte is 0 for write and 1 for read. After any other address the block gives no acknowledge and makes no write until the next START.
- R4: Bits move most significant first and are sampled while SCL is high. The block changes its SDA drive only while SCL is low, except on a timeout release. It holds SDA low through the ninth clock of every byte it receives.
- R5: In a write, the first byte after the address loads the pointer from its low 4 bits. Each later byte is acknowledged, stored at the pointer, and shown as a one-cycle `wr_en` pulse with `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R6: The pointer advances by one after each data byte written or loaded for reading, wrapping from 15 to 0.
- R7: After a repeated START with the read address, the block sends the register at the pointer and then the following registers, one per byte, as long as the host acknowledges.
- R8: When the host answers a read byte with NACK, the block stops driving SDA until the next START or STOP.
- R9: If no STOP follows a START within (CLK_HZ/100)*95 clock cycles, the block releases SDA. It then acknowledges nothing and writes nothing until the next START.
- R10: A repeated START does not restart the transaction time limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en | output | 1 | One-cycle strobe per written data byte |
| wr_addr | output | 4 | Register index of the write |
| wr_data | output | 8 | Byte written |

## Verification
Several rules are checked on every cycle: SDA drive changes only while SCL is low unless a timeout fired; a STOP, a NACK, a foreign address or a timeout leaves SDA released in the next cycle; the write strobe never lasts two cycles; and the timer neither restarts on a repeated START nor passes its limit. Only the bench scenarios show the register traffic itself. These are the data landing at the right index, the pointer advancing and wrapping, reads returning the bank contents in order, a mid-byte START abandoning the byte, and bytes sent after a timeout drawing no acknowledge and no write.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK
   } rp_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ch, sda_ch;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ch <= '1;
         sda_ch <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ch <= {scl_ch[STAGES-2:0], scl_i};
         sda_ch <= {sda_ch[STAGES-2:0], sda_i};
         scl_d  <= scl_ch[STAGES-1];
         sda_d  <= sda_ch[STAGES-1];
      end
   end

   assign scl_q     = scl_ch[STAGES-1];
   assign sda_q     = sda_ch[STAGES-1];
   assign scl_rise  = scl_q & ~scl_d;
   assign scl_fall  = ~scl_q & scl_d;
   assign start_det = scl_q & scl_d & sda_d & ~sda_q;
   assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_txn_timer.sv
module i2c_txn_timer #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_det,
   input  logic stop_det,
   output logic expire
);
   localparam int CW = $clog2(LIMIT);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("i2c_txn_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic          active;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (stop_det) begin
            active <= 1'b0;
         end else if (active) begin
            if (cnt == CW'(LIMIT - 1)) begin
               active <= 1'b0;
               expire <= 1'b1;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end else if (start_det) begin
            active <= 1'b1;
            cnt    <= '0;
         end
      end
   end

   // R10: a repeated START while running keeps counting
   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (active && start_det && !stop_det && cnt != CW'(LIMIT - 1))
      |=> (cnt == $past(cnt) + CW'(1)));

   // R9: the counter never passes the limit
   a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
   parameter int          COUNT     = 16,
   parameter int          DW        = 8,
   parameter logic [7:0]  RESET_VAL = 8'h00,
   localparam int         AW        = $clog2(COUNT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] regs [COUNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < COUNT; i++) regs[i] <= DW'(RESET_VAL);
      end else if (we) begin
         regs[waddr] <= wdata;
      end
   end

   assign rdata = regs[raddr];
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
   import i2c_regport_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter logic [6:0]  DEV_ADDR    = 7'b0110010,
   parameter int          REG_COUNT   = 16,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  RESET_VALUE = 8'h00,
   localparam int         AW          = $clog2(REG_COUNT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data
);
   localparam int unsigned LIMIT = (CLK_HZ / 100) * 95;

   generate
      if (REG_COUNT < 2 || (1 << AW) != REG_COUNT) begin : g_bad_count
         $error("i2c_regport: REG_COUNT must be a power of two");
      end
      if (AW > BYTE_W) begin : g_bad_width
         $error("i2c_regport: pointer wider than a byte");
      end
   endgenerate

   logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det, tmo;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2c_txn_timer #(.LIMIT(LIMIT)) i_timer (
      .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
      .expire(tmo));

   rp_state_t         state;
   logic [3:0]        cnt;
   logic [7:0]        sh, tx;
   logic [AW-1:0]     ptr;
   logic              rd_mode, host_nack;
   logic [7:0]        rdata;

   i2c_regbank #(.COUNT(REG_COUNT), .DW(BYTE_W), .RESET_VAL(RESET_VALUE)) i_bank (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
      .raddr(ptr), .rdata(rdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         sh        <= '0;
         tx        <= '0;
         ptr       <= '0;
         rd_mode   <= 1'b0;
         host_nack <= 1'b0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (tmo) begin
            state <= ST_IDLE;
         end else if (start_det) begin
            state <= ST_ADDR;
            cnt   <= '0;
         end else if (stop_det) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_ADDR, ST_PTR, ST_WDATA: begin
                  if (scl_rise) begin
                     sh  <= {sh[6:0], sda_q};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (sh[7:1] == DEV_ADDR) begin
                           rd_mode <= sh[0];
                           state   <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_PTR) begin
                        ptr   <= sh[AW-1:0];
                        state <= ST_PTR_ACK;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= sh;
                        ptr     <= ptr + AW'(1);
                        state   <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rd_mode) begin
                        tx    <= rdata;
                        ptr   <= ptr + AW'(1);
                        state <= ST_RDATA;
                     end else begin
                        state <= ST_PTR;
                     end
                  end
               end
               ST_PTR_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     cnt   <= '0;
                     state <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (cnt == 4'd7) begin
                        cnt   <= '0;
                        state <= ST_RACK;
                     end else begin
                        tx  <= {tx[6:0], 1'b0};
                        cnt <= cnt + 4'd1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     host_nack <= sda_q;
                  end else if (scl_fall) begin
                     if (host_nack) begin
                        state <= ST_IDLE;
                     end else begin
                        tx    <= rdata;
                        ptr   <= ptr + AW'(1);
                        cnt   <= '0;
                        state <= ST_RDATA;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (state)
         ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
         ST_RDATA:                              sda_oe = ~tx[7];
         default:                               sda_oe = 1'b0;
      endcase
   end

   // R2: a STOP leaves SDA released
   a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R4: drive changes only while SCL is low, unless a timeout fired
   a_r4_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> (!scl_q || $past(tmo)));

   // R3: a foreign address is not acknowledged
   a_r3_foreign_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR && !start_det && !stop_det && !tmo && scl_fall &&
       cnt == 4'd8 && sh[7:1] != DEV_ADDR) |=> !sda_oe);

   // R5: the write strobe lasts exactly one cycle
   a_r5_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R8: a host NACK releases SDA
   a_r8_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK && scl_fall && host_nack) |=> !sda_oe);

   // R9: timeout returns to idle with SDA released
   a_r9_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> (state == ST_IDLE && !sda_oe));
endmodule

// File: tb/test_i2c_regport.sv
module test_i2c_regport;
   localparam int unsigned CLK_HZ = 20_000;
   localparam int LIMIT = (CLK_HZ / 100) * 95;
   localparam int H = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_h = 1'b1, sda_h = 1'b1;
   logic sda_oe, wr_en;
   logic [3:0] wr_addr;
   logic [7:0] wr_data;
   wire sda_line = sda_h & ~sda_oe;

   always #10 clk = ~clk;

   i2c_regport #(.CLK_HZ(CLK_HZ)) i_i2c_regport (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
      .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

   int errors = 0, checks = 0;
   int strobes = 0;
   logic [3:0] last_wa = '0;
   logic [7:0] last_wd = '0;
   logic [7:0] mdl [16];
   logic [7:0] wbuf [8];
   int cycles = 0;

   always @(posedge clk) begin
      if (wr_en) begin
         strobes <= strobes + 1;
         last_wa <= wr_addr;
         last_wd <= wr_data;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic hw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_h = 1'b1; hw(H/2); scl_h = 1'b1; hw(H);
      sda_h = 1'b0; hw(H); scl_h = 1'b0; hw(H/2);
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; hw(H/2); scl_h = 1'b1; hw(H);
      sda_h = 1'b1; hw(H);
   endtask

   task automatic bus_bit(input logic b, output logic r);
      sda_h = b; hw(H/2); scl_h = 1'b1; hw(H/2);
      r = sda_line; hw(H/2); scl_h = 1'b0; hw(H/2);
   endtask

   task automatic wbyte(input logic [7:0] v, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
      bus_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic rbyte(input bit give_ack, output logic [7:0] v);
      logic r;
      v = '0;
      for (int i = 0; i < 8; i++) begin
         bus_bit(1'b1, r);
         v = {v[6:0], r};
      end
      bus_bit(give_ack ? 1'b0 : 1'b1, r);
   endtask

   // full write transaction: pointer p, n bytes from wbuf
   task automatic do_write(input int p, input int n);
      logic ack;
      int s0 = strobes;
      bus_start();
      wbyte(8'h64, ack); check(ack, "R3", "write address ack", ack, 1);
      wbyte(8'(p), ack); check(ack, "R5", "pointer ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         wbyte(wbuf[i], ack);
         check(ack, "R5", "data ack", ack, 1);
         mdl[(p + i) % 16] = wbuf[i];
      end
      bus_stop();
      check(strobes == s0 + n, "R5", "strobe count", strobes - s0, n);
      check(last_wa == 4'((p + n - 1) % 16), "R6", "last strobe index",
            last_wa, (p + n - 1) % 16);
      check(last_wd == wbuf[n-1], "R5", "last strobe data", last_wd, wbuf[n-1]);
   endtask

   task automatic do_read(input int p, input int n);
      logic ack;
      logic [7:0] v;
      bus_start();
      wbyte(8'h64, ack); check(ack, "R3", "write address ack", ack, 1);
      wbyte(8'(p), ack); check(ack, "R5", "pointer ack", ack, 1);
      bus_start();
      wbyte(8'h65, ack); check(ack, "R3", "read address ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         rbyte(i < n - 1, v);
         check(v == mdl[(p + i) % 16], "R7", "read byte", v, mdl[(p + i) % 16]);
      end
      bus_stop();
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190_000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190_000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      logic ack;
      logic [7:0] v;
      int s0;
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
      hw(5); rst_n = 1'b1; hw(5);
      check(sda_oe == 1'b0, "R1", "reset sda_oe", sda_oe, 0);
      check(wr_en == 1'b0, "R1", "reset wr_en", wr_en, 0);

      // R4 MSB ordering with asymmetric values
      wbuf[0] = 8'h80; wbuf[1] = 8'h01; wbuf[2] = 8'hC3;
      do_write(4, 3);
      do_read(4, 3);
      check(sda_oe == 1'b0, "R1", "idle after read", sda_oe, 0);

      // R6 wrap 15 -> 0
      wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
      do_write(15, 2);
      do_read(15, 2);

      // R3 foreign address: no ack, no write
      s0 = strobes;
      bus_start();
      wbyte(8'h66, ack); check(!ack, "R3", "foreign address nack", ack, 0);
      wbyte(8'h02, ack); check(!ack, "R3", "ignored pointer", ack, 0);
      wbyte(8'h77, ack); check(!ack, "R3", "ignored data", ack, 0);
      bus_stop();
      check(strobes == s0, "R3", "no strobe", strobes - s0, 0);

      // R2 START in the middle of a byte abandons it
      s0 = strobes;
      bus_start();
      wbyte(8'h64, ack); wbyte(8'h02, ack);
      bus_bit(1'b1, ack); bus_bit(1'b0, ack); bus_bit(1'b1, ack);
      bus_start();
      wbyte(8'h64, ack); check(ack, "R2", "address after restart", ack, 1);
      wbyte(8'h02, ack);
      wbyte(8'h11, ack); mdl[2] = 8'h11;
      bus_stop();
      check(strobes == s0 + 1, "R2", "one strobe after restart", strobes - s0, 1);
      do_read(2, 1);

      // R8 NACK releases SDA
      bus_start();
      wbyte(8'h64, ack); wbyte(8'h04, ack);
      bus_start();
      wbyte(8'h65, ack);
      rbyte(1'b0, v); check(v == mdl[4], "R8", "byte before nack", v, mdl[4]);
      rbyte(1'b1, v); check(v == 8'hFF, "R8", "released after nack", v, 8'hFF);
      bus_stop();

      // R9 timeout: ignore until next START
      s0 = strobes;
      bus_start();
      wbyte(8'h64, ack); check(ack, "R9", "ack before timeout", ack, 1);
      hw(LIMIT + 500);
      check(sda_oe == 1'b0, "R9", "released at timeout", sda_oe, 0);
      wbyte(8'h03, ack); check(!ack, "R9", "pointer after timeout", ack, 0);
      wbyte(8'hEE, ack); check(!ack, "R9", "data after timeout", ack, 0);
      bus_stop();
      check(strobes == s0, "R9", "no strobe after timeout", strobes - s0, 0);
      do_read(3, 1);

      // R10 repeated START does not restart the limit
      wbuf[0] = 8'h5A;
      do_write(5, 1);
      bus_start();
      wbyte(8'h64, ack); wbyte(8'h05, ack);
      hw(LIMIT * 6 / 10);
      bus_start();
      wbyte(8'h65, ack); check(ack, "R10", "read address in time", ack, 1);
      hw(LIMIT * 6 / 10);
      rbyte(1'b0, v); check(v == 8'hFF, "R10", "expired despite restart", v, 8'hFF);
      bus_stop();

      // random traffic
      for (int t = 0; t < 24; t++) begin
         int p = $urandom_range(0, 15);
         int n = $urandom_range(1, 5);
         if ($urandom_range(0, 1) == 1) begin
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(p, n);
         end else begin
            do_read(p, n);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule